// File: doc/BRIEF.md
# CAN Transmit Buffer and Status Control

This block sits between a host CPU and the protocol engine of a CAN controller. It holds one transmit buffer, a small byte array that the CPU fills before asking for a frame to be sent. The block also keeps the status bits the CPU polls: whether the buffer may be written, whether the last transmission finished, and whether the controller is transmitting, receiving or the bus is idle.

The CPU writes bytes while the buffer is released, then issues either a transmit request or a self-reception request. Either request locks the buffer and clears the completion bit. The protocol engine reads the buffer through a separate read port. It reports frame start, successful completion or abort. Completion or abort releases the buffer again. Only a successful completion sets the completion bit.

Top module: `can_txbuf_ctrl`

## Requirements
- R1: After reset, buf_released_o=1, tx_complete_o=1, tx_status_o=0, rx_status_o=0, bus_idle_o=1, req_o=0, req_self_o=0, and every buffer byte reads 0.
- R2: A write with wr_en_i=1 while buf_released_o=1 stores wr_data_i at wr_addr_i. The byte is visible on rd_data_o for that address from the next cycle. A write in the same cycle as an accepted request is still stored.
- R3: A write while buf_released_o=0 leaves the buffer contents unchanged and raises no flag. buf_released_o stays 0.
- R4: A tx_req_i or self_req_i pulse while released gives buf_released_o=0, tx_complete_o=0 and req_o=1 on the next cycle. req_self_o=1 only when self_req_i alone was asserted; tx_req_i takes priority.
- R5: Once cleared, tx_complete_o stays 0 until a successful completion.
- R6: tx_done_i while locked sets tx_complete_o=1 and buf_released_o=1 on the same next cycle, and drops req_o and tx_status_o. If tx_abort_i is high in the same cycle, completion wins.
- R7: tx_abort_i alone while locked gives buf_released_o=1 with tx_complete_o still 0.
- R8: tx_status_o goes to 1 the cycle after frame_start_i is seen while a request is pending. It returns to 0 the cycle after completion or abort. frame_start_i while released has no effect.
- R9: rx_status_o equals rx_active_i delayed by one cycle.
- R10: bus_idle_o=1 exactly when tx_status_o=0 and rx_status_o=0.
- R11: A request while the buffer is locked is ignored, and so is completion or abort while released. None of them changes any status output or req_self_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU buffer write strobe |
| wr_addr_i | input | AW | CPU write byte address |
| wr_data_i | input | 8 | CPU write data |
| rd_addr_i | input | AW | Engine read byte address |
| rd_data_o | output | 8 | Engine read data (0 beyond depth) |
| tx_req_i | input | 1 | Transmit request command pulse |
| self_req_i | input | 1 | Self-reception request command pulse |
| frame_start_i | input | 1 | Engine begins frame output |
| tx_done_i | input | 1 | Engine reports successful transmission |
| tx_abort_i | input | 1 | Engine reports abort |
| rx_active_i | input | 1 | Engine is receiving |
| req_o | output | 1 | Request pending toward engine |
| req_self_o | output | 1 | Pending request is self-reception |
| buf_released_o | output | 1 | Buffer writable (1) or locked (0) |
| tx_complete_o | output | 1 | Last requested transmission finished successfully |
| tx_status_o | output | 1 | Frame output in progress |
| rx_status_o | output | 1 | Reception in progress |
| bus_idle_o | output | 1 | Neither transmitting nor receiving |

## Verification
The bench writes into a locked buffer and reads the byte back. A design that let the write through would return the new value. A design that flagged the write would disturb buf_released_o. It raises done and abort together, where an abort-first design would leave the completion bit clear. It also sends completion, abort and frame-start pulses while released, which a careless state machine would act on. Other cases are a request issued while locked, a write issued in the same cycle as a request, and receive activity overlapping transmit, each of which shows up as a wrong buffer byte, req_self_o or bus_idle_o.

// File: rtl/can_txbuf_pkg.sv
`timescale 1ns/1ps
package can_txbuf_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_SEND = 2'd2
  } txbuf_state_e;
endpackage

// File: rtl/can_txbuf_store.sv
`timescale 1ns/1ps
module can_txbuf_store #(
  parameter int DEPTH = 13,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_allow_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [DEPTH-1:0][7:0] mem_q;
  logic                  wr_go;

  assign wr_go = wr_en_i & wr_allow_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= 8'h00;
      else if (wr_go && (wr_addr_i == AW'(g)))    mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if ({1'b0, rd_addr_i} < (AW+1)'(DEPTH)) rd_data_o = mem_q[rd_addr_i];
  end

  AST_LOCKED_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_allow_i |=> $stable(mem_q)); // R3
endmodule

// File: rtl/can_txbuf_status.sv
`timescale 1ns/1ps
module can_txbuf_status
  import can_txbuf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_req_i,
  input  logic self_req_i,
  input  logic frame_start_i,
  input  logic tx_done_i,
  input  logic tx_abort_i,
  output logic released_o,
  output logic complete_o,
  output logic tx_status_o,
  output logic req_o,
  output logic req_self_o
);
  txbuf_state_e state_q;
  logic         cmp_q;
  logic         self_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      cmp_q   <= 1'b1;
      self_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FREE: if (tx_req_i || self_req_i) begin
          state_q <= ST_PEND;
          cmp_q   <= 1'b0;
          self_q  <= self_req_i & ~tx_req_i;
        end
        ST_PEND, ST_SEND: begin
          if (tx_done_i) begin
            state_q <= ST_FREE;
            cmp_q   <= 1'b1;  // done wins over abort
          end else if (tx_abort_i) begin
            state_q <= ST_FREE;
          end else if (frame_start_i && state_q == ST_PEND) begin
            state_q <= ST_SEND;
          end
        end
        default: state_q <= ST_FREE;
      endcase
    end
  end

  assign released_o  = (state_q == ST_FREE);
  assign tx_status_o = (state_q == ST_SEND);
  assign req_o       = ~released_o;
  assign complete_o  = cmp_q;
  assign req_self_o  = self_q & req_o;

  AST_REQ_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (released_o && (tx_req_i || self_req_i)) |=> (!released_o && !complete_o)); // R4
  AST_CMP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!complete_o && !(tx_done_i && !released_o)) |=> !complete_o); // R5
  AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !released_o) |=> (complete_o && released_o && !tx_status_o)); // R6
  AST_ABORT_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_abort_i && !tx_done_i && !released_o) |=> (released_o && !complete_o)); // R7
  AST_TXS_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_status_o |-> !released_o); // R8
  AST_LOCKED_REQ_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!released_o && !tx_done_i && !tx_abort_i) |=> $stable(req_self_o)); // R11
endmodule

// File: rtl/can_bus_activity.sv
`timescale 1ns/1ps
module can_bus_activity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_active_i,
  input  logic tx_status_i,
  output logic rx_status_o,
  output logic bus_idle_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_active_i;
  end

  assign rx_status_o = rx_q;
  assign bus_idle_o  = ~(rx_q | tx_status_i);

  AST_RX_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rx_status_o == $past(rx_active_i))); // R9
endmodule

// File: rtl/can_txbuf_ctrl.sv
`timescale 1ns/1ps
module can_txbuf_ctrl #(
  parameter int DEPTH = 13,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          tx_req_i,
  input  logic          self_req_i,
  input  logic          frame_start_i,
  input  logic          tx_done_i,
  input  logic          tx_abort_i,
  input  logic          rx_active_i,
  output logic          req_o,
  output logic          req_self_o,
  output logic          buf_released_o,
  output logic          tx_complete_o,
  output logic          tx_status_o,
  output logic          rx_status_o,
  output logic          bus_idle_o
);
  logic released;
  logic tx_stat;

  can_txbuf_status u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_req_i      (tx_req_i),
    .self_req_i    (self_req_i),
    .frame_start_i (frame_start_i),
    .tx_done_i     (tx_done_i),
    .tx_abort_i    (tx_abort_i),
    .released_o    (released),
    .complete_o    (tx_complete_o),
    .tx_status_o   (tx_stat),
    .req_o         (req_o),
    .req_self_o    (req_self_o)
  );

  can_txbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_allow_i (released),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  can_bus_activity u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_active_i (rx_active_i),
    .tx_status_i (tx_stat),
    .rx_status_o (rx_status_o),
    .bus_idle_o  (bus_idle_o)
  );

  assign buf_released_o = released;
  assign tx_status_o    = tx_stat;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o |-> (!tx_status_o && !rx_status_o)); // R10
endmodule

// File: tb/can_txbuf_ctrl_bench.sv
`timescale 1ns/1ps
module can_txbuf_ctrl_bench;
  localparam int DEPTH = 13;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic tx_req = 0, self_req = 0, fstart = 0, done = 0, abort = 0, rxa = 0;
  logic req, req_self, rel, cmp, txs, rxs, idle;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_txbuf_ctrl #(.DEPTH(DEPTH)) u_can_txbuf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tx_req_i(tx_req), .self_req_i(self_req), .frame_start_i(fstart),
    .tx_done_i(done), .tx_abort_i(abort), .rx_active_i(rxa),
    .req_o(req), .req_self_o(req_self), .buf_released_o(rel),
    .tx_complete_o(cmp), .tx_status_o(txs), .rx_status_o(rxs), .bus_idle_o(idle)
  );

  // inputs {tx,self,fs,done,abort,rxa} | expected {rel,cmp,txs,rxs,idle} | tag
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {6'b000000, 5'b11001, 4'd1},   // R1 idle
    {6'b100000, 5'b00001, 4'd4},   // R4 tx request
    {6'b001000, 5'b00100, 4'd8},   // R8 frame start
    {6'b000000, 5'b00100, 4'd5},   // R5 hold
    {6'b000100, 5'b11001, 4'd6},   // R6 done
    {6'b010000, 5'b00001, 4'd4},   // R4 self request
    {6'b001001, 5'b00110, 4'd10},  // R10 both busy
    {6'b000011, 5'b10010, 4'd7},   // R7 abort
    {6'b000000, 5'b10001, 4'd9},   // R9 rx falls
    {6'b000100, 5'b10001, 4'd11},  // R11 done while released
    {6'b000001, 5'b10010, 4'd9},   // R9 rx only
    {6'b100000, 5'b00001, 4'd4},   // R4
    {6'b101000, 5'b00100, 4'd11},  // R11 request while locked
    {6'b000110, 5'b11001, 4'd6},   // R6 done beats abort
    {6'b001000, 5'b11001, 4'd8}    // R8 frame start while released
  };

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    {tx_req, self_req, fstart, done, abort, wr_en} = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, {27'd0, rel, cmp, txs, rxs, idle}, 32'b11001);
    chk(1, {30'd0, req, req_self}, 32'd0);
    rd_addr = AW'(5); #1 chk(1, rd_data, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {tx_req, self_req, fstart, done, abort, rxa} = VEC[i][14:9];
      tick();
      chk(int'(VEC[i][3:0]), {27'd0, rel, cmp, txs, rxs, idle}, {27'd0, VEC[i][8:4]});
      if (i == 5)  chk(4, req_self, 1'b1);   // R4 self only
      if (i == 12) chk(11, req_self, 1'b0);  // R11 unchanged
    end
    pulse_clear(); rxa = 0;
    tick();

    // R2 write while released
    @(negedge clk); wr_en = 1; wr_addr = AW'(2); wr_data = 8'hA5;
    pulse_clear(); rd_addr = AW'(2); #1 chk(2, rd_data, 8'hA5);

    // R2 write same cycle as request is kept; R4 tx wins over self
    wr_en = 1; wr_addr = AW'(3); wr_data = 8'h77; tx_req = 1; self_req = 1;
    tick();
    rd_addr = AW'(3); #1 chk(2, rd_data, 8'h77);
    chk(4, {30'd0, req, req_self}, 32'b10);
    pulse_clear();

    // R3 write while locked is dropped silently
    wr_en = 1; wr_addr = AW'(2); wr_data = 8'h3C;
    pulse_clear(); rd_addr = AW'(2); #1 chk(3, rd_data, 8'hA5);
    chk(3, rel, 1'b0);
    chk(5, cmp, 1'b0);

    // R6 completion frees buffer, then write accepted again
    done = 1; tick(); chk(6, {30'd0, rel, cmp}, 32'b11); chk(6, req, 1'b0);
    pulse_clear();
    wr_en = 1; wr_addr = AW'(2); wr_data = 8'h3C;
    pulse_clear(); #1 chk(2, rd_data, 8'h3C);

    // read beyond depth returns 0
    rd_addr = AW'(DEPTH); #1 chk(2, rd_data, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule